// File: doc/BRIEF.md
# Bounded Triangle Digit Sequencer

This block produces a 4-bit digit that climbs one step at a time up to a high bound, then falls one step at a time down to a low bound, and repeats, giving a triangle-shaped sequence. Steps happen only on a slow internal tick, one clock wide, that fires once every `CYCLE` clocks. The default `CYCLE` of 50,000,000 gives one step per second from a 50 MHz clock. A bench or a fast model can set it to a small value such as 5.

Both bounds are plain inputs and may change while the block runs. A small direction state machine watches the current digit against the bounds. It turns the count downward at or above the high bound, turns it upward at or below the low bound, and otherwise keeps the present direction. When the two bounds are equal and the digit sits on them, the digit stays where it is. The current digit and the current direction are both outputs.

Top module: `tri_wave_gen`

## Requirements
- R1: While reset (`rst_ni` low) is applied and right after it is released, `value_o` is 0 and `dir_o` is 0 (0 means counting up, 1 means counting down).
- R2: After reset is released, the first step of `value_o` appears on the clock edge CYCLE+1 after release. Every later step follows the one before it by a whole multiple of CYCLE clocks, and by exactly CYCLE clocks while the digit is not held.
- R3: Each internal tick is high for exactly one clock, so every tick moves `value_o` by exactly one.
- R4: On a tick, `value_o` rises by one when `dir_o` is 0 and falls by one when `dir_o` is 1. Between ticks, `value_o` holds its value.
- R5: One clock after `value_o` equals `lim_hi_i`, `dir_o` is 1. One clock after `value_o` equals `lim_lo_i` (and is below `lim_hi_i`), `dir_o` is 0. While the digit lies strictly between the bounds, `dir_o` keeps its value.
- R6: A digit above `lim_hi_i` forces `dir_o` to 1, and a digit below `lim_lo_i` forces `dir_o` to 0. If both hold (inverted bounds), the high-bound rule takes priority.
- R7: When `lim_lo_i` equals `lim_hi_i` and `value_o` equals both, `value_o` does not change on later ticks.
- R8: A change of either bound is used by the clock after it is applied, so it decides the direction of the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for all registers |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lim_lo_i | input | 4 | Low turning bound |
| lim_hi_i | input | 4 | High turning bound |
| value_o | output | 4 | Current sequence digit |
| dir_o | output | 1 | Current direction, 0 up, 1 down |

## Verification
A direction register stuck or set wrongly shows at the ports at the next tick: the digit steps past a bound, or moves away from it when it should turn. `dir_o` itself shows the error one clock after the digit reaches a bound. A tick divider that is off by any count shows as a wrong gap between digit changes, already at the first step after reset. A tick held for two clocks shows as a double step. The scoreboard compares every digit change, the direction one clock later, and the gap since the previous change. It covers normal bouncing, bounds moved during operation to above and below the digit, inverted bounds and equal bounds.

// File: rtl/twg_pkg.sv
package twg_pkg;

   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } dir_e;

endpackage

// File: rtl/twg_tick.sv
module twg_tick #(
   parameter int unsigned CYCLE = 50_000_000
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);

   localparam int unsigned CW = (CYCLE > 1) ? $clog2(CYCLE) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYCLE - 1);

   logic [CW-1:0] cnt_q;
   logic          wrap;

   assign wrap = (cnt_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         tick_o <= 1'b0;
      end else begin
         cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
         tick_o <= wrap;
      end
   end

endmodule

// File: rtl/twg_updown.sv
module twg_updown
   import twg_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  dir_e             dir_i,
   output logic [WIDTH-1:0] value_o
);

   logic [WIDTH-1:0] value_d;

   always_comb begin
      value_d = value_o;
      if (en_i) begin
         if (dir_i == DIR_DOWN) value_d = value_o - 1'b1;
         else                   value_d = value_o + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) value_o <= '0;
      else         value_o <= value_d;
   end

endmodule

// File: rtl/twg_dirfsm.sv
module twg_dirfsm
   import twg_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] value_i,
   input  logic [WIDTH-1:0] lo_i,
   input  logic [WIDTH-1:0] hi_i,
   output dir_e             dir_o,
   output logic             park_o
);

   dir_e state_q;
   dir_e state_d;

   always_comb begin
      state_d = state_q;
      if (value_i >= hi_i)      state_d = DIR_DOWN;
      else if (value_i <= lo_i) state_d = DIR_UP;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= DIR_UP;
      else         state_q <= state_d;
   end

   assign dir_o  = state_q;
   assign park_o = (value_i == lo_i) && (value_i == hi_i);

endmodule

// File: rtl/tri_wave_gen.sv
module tri_wave_gen
   import twg_pkg::*;
#(
   parameter int unsigned WIDTH = 4,
   parameter int unsigned CYCLE = 50_000_000
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] lim_lo_i,
   input  logic [WIDTH-1:0] lim_hi_i,
   output logic [WIDTH-1:0] value_o,
   output logic             dir_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("tri_wave_gen: WIDTH must be at least 1");
   end
   if (CYCLE < 2) begin : g_bad_cycle
      $error("tri_wave_gen: CYCLE must be at least 2 for a one-clock tick");
   end

   logic tick;
   logic park;
   logic cnt_en;
   dir_e dir;

   twg_tick #(.CYCLE(CYCLE)) i_tick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_o (tick)
   );

   assign cnt_en = tick & ~park;

   twg_updown #(.WIDTH(WIDTH)) i_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (cnt_en),
      .dir_i   (dir),
      .value_o (value_o)
   );

   twg_dirfsm #(.WIDTH(WIDTH)) i_dir (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .value_i (value_o),
      .lo_i    (lim_lo_i),
      .hi_i    (lim_hi_i),
      .dir_o   (dir),
      .park_o  (park)
   );

   assign dir_o = dir;

endmodule

// File: rtl/tri_wave_gen_chk.sv
module tri_wave_gen_chk #(
   parameter int unsigned WIDTH = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic [WIDTH-1:0] value,
   input logic             dir,
   input logic [WIDTH-1:0] lo,
   input logic [WIDTH-1:0] hi
);

   AST_TICK_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);  // R3

   AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(value));  // R4

   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !dir && !(value == lo && value == hi) |=> value == WIDTH'($past(value) + 1'b1));  // R4

   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      tick && dir && !(value == lo && value == hi) |=> value == WIDTH'($past(value) - 1'b1));  // R4

   AST_TURN_AT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      value >= hi |=> dir);  // R5

   AST_TURN_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      value < hi && value <= lo |=> !dir);  // R6

   AST_KEEP_DIR_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      value < hi && value > lo |=> dir == $past(dir));  // R5

   AST_PARKED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      value == lo && value == hi && $stable(lo) && $stable(hi) |=> $stable(value));  // R7

endmodule

bind tri_wave_gen tri_wave_gen_chk #(.WIDTH(WIDTH)) i_chk (
   .clk   (clk_i),
   .rst_n (rst_ni),
   .tick  (tick),
   .value (value_o),
   .dir   (dir_o),
   .lo    (lim_lo_i),
   .hi    (lim_hi_i)
);

// File: tb/test_tri_wave_gen.sv
module test_tri_wave_gen;

   localparam int unsigned CYC = 5;

   typedef struct {
      logic [3:0] v;
      logic       d;
      string      tag;
   } exp_t;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic [3:0] lim_lo_i = 4'd6;
   logic [3:0] lim_hi_i = 4'd9;
   logic [3:0] value_o;
   logic       dir_o;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   logic [3:0] m_v = 4'd0;
   logic       m_d = 1'b0;

   always #2 clk_i = ~clk_i;

   tri_wave_gen #(.WIDTH(4), .CYCLE(CYC)) i_tri_wave_gen (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lim_lo_i (lim_lo_i),
      .lim_hi_i (lim_hi_i),
      .value_o  (value_o),
      .dir_o    (dir_o)
   );

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   // reference model of one bounce step; returns 0 when held at equal bounds
   function automatic bit model_step(string tag);
      exp_t e;
      if (m_v == lim_hi_i && m_v == lim_lo_i) return 1'b0;
      if (m_v >= lim_hi_i)      m_d = 1'b1;
      else if (m_v <= lim_lo_i) m_d = 1'b0;
      m_v = m_d ? m_v - 4'd1 : m_v + 4'd1;
      if (m_v >= lim_hi_i)      m_d = 1'b1;
      else if (m_v <= lim_lo_i) m_d = 1'b0;
      e.v = m_v; e.d = m_d; e.tag = tag;
      q.push_back(e);
      return 1'b1;
   endfunction

   task automatic drive(input logic [3:0] lo, input logic [3:0] hi, input int n, input string tag);
      lim_lo_i = lo;
      lim_hi_i = hi;
      for (int i = 0; i < n; i++) begin
         if (!model_step(tag)) break;
      end
      wait (q.size() == 0);
      #1;
   endtask

   // monitor / scoreboard
   int         cyc = 0;
   int         last_chg = 0;
   bit         first = 1'b1;
   bit         dir_pend = 1'b0;
   exp_t       cur;
   logic [3:0] prev_v = 4'd0;

   always @(negedge clk_i) begin
      if (rst_ni && !done) begin
         cyc++;
         if (dir_pend) begin
            check(dir_o === cur.d, $sformatf("R5 dir after digit %0d (%s)", cur.v, cur.tag),
                  dir_o, cur.d);
            dir_pend = 1'b0;
         end
         if (value_o !== prev_v) begin
            if (q.size() == 0) begin
               check(1'b0, "R7 unexpected digit change", value_o, prev_v);
            end else begin
               cur = q.pop_front();
               check(value_o === cur.v, $sformatf("R4 digit, R3 single step (%s)", cur.tag),
                     value_o, cur.v);
               dir_pend = 1'b1;
            end
            if (first)
               check(cyc - last_chg == CYC + 1, "R2 first step delay", cyc - last_chg, CYC + 1);
            else
               check((cyc - last_chg) % CYC == 0, "R2 step spacing", cyc - last_chg, CYC);
            first    = 1'b0;
            last_chg = cyc;
            prev_v   = value_o;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk_i);
      check(value_o === 4'd0, "R1 digit in reset", value_o, 0);
      check(dir_o === 1'b0, "R1 dir in reset", dir_o, 0);
      #1 rst_ni = 1'b1;
      @(negedge clk_i);
      check(value_o === 4'd0, "R1 digit after release", value_o, 0);
      check(dir_o === 1'b0, "R1 dir after release", dir_o, 0);
      drive(4'd6, 4'd9, 16, "R5 bounce 6..9");
      drive(4'd2, 4'd4, 10, "R6 R8 digit above new high");
      drive(4'd7, 4'd9, 8, "R6 R8 digit below new low");
      drive(4'd9, 4'd3, 6, "R6 inverted bounds");
      drive(4'd5, 4'd5, 20, "R7 equal bounds");
      repeat (6 * CYC) @(negedge clk_i);
      check(value_o === 4'd5, "R7 digit held on equal bounds", value_o, 5);
      check(dir_o === 1'b1, "R7 dir on equal bounds", dir_o, 1);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule